// File: doc/BRIEF.md
# Shift-Subtract Unsigned Divider with Fraction Mode

This block divides one unsigned 16-bit operand by another over several clocks. It has two modes, and both use the same restoring shift-subtract datapath. In integer mode it returns the whole-number quotient and the remainder. In fraction mode the dividend must be smaller than the divisor. Both operands are read with the same radix-point position, and the block returns a 16-bit binary fraction whose radix point lies just above the most significant quotient bit, together with the remainder of that division.

A caller presents the operands and the mode bit and pulses `start` for one cycle. When the result is ready, the block raises `done` for one cycle. The results and the carry, overflow and zero flags then stay unchanged until the next result. Two cases bypass the iterations and return a fixed answer one cycle after `start`: a zero divisor, and a fraction-mode dividend that is not below the divisor.

Top module: `shift_sub_divider`

## Requirements
- R1: With `frac_mode`=0 and a nonzero divisor, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor.
- R2: With `frac_mode`=1 and dividend < divisor, `quotient` equals floor(dividend·65536/divisor) and `remainder` equals (dividend·65536) mod divisor.
- R3: In either mode, a divisor of 0x0000 gives `quotient`=0xFFFF, `remainder`=0xFFFF, `carry_flag`=1, `ovf_flag`=0 and `zero_flag`=0, with `done` high in the cycle after the start edge.
- R4: When a division iterates, `done` is high for exactly one cycle. That cycle follows the 16th rising edge after the edge that sampled `start`.
- R5: With `frac_mode`=1, a nonzero divisor and dividend ≥ divisor, the block gives `quotient`=0xFFFF, `remainder`=dividend, `ovf_flag`=1, `carry_flag`=0 and `zero_flag`=0, with `done` high in the cycle after the start edge.
- R6: For every result with a nonzero divisor, `carry_flag` is 0. `zero_flag` is 1 exactly when `quotient` is 0x0000. `ovf_flag` is 0 unless R5 applies.
- R7: `quotient`, `remainder` and all three flags change only on the edge that raises `done`. They hold their values at all other times.
- R8: A `start` pulse that arrives while a division is iterating is ignored. It does not change the running result, the latency or the number of `done` pulses.
- R9: After synchronous reset, `quotient`, `remainder` and all three flags are zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a division |
| frac_mode | input | 1 | 0 = integer division, 1 = fraction division |
| dividend | input | 16 | Unsigned dividend, sampled with start |
| divisor | input | 16 | Unsigned divisor, sampled with start |
| quotient | output | 16 | Integer quotient or binary fraction |
| remainder | output | 16 | Remainder of the division |
| carry_flag | output | 1 | Set on divide by zero |
| ovf_flag | output | 1 | Set when a fraction quotient would reach one |
| zero_flag | output | 1 | Set when the quotient is zero |
| done | output | 1 | One-cycle pulse when a new result is presented |

## Verification
On every cycle, the assertions check four things. The partial remainder stays below the divisor while the block iterates. Both shortcut cases produce their fixed results one cycle after launch. A busy period always ends with a `done` pulse, and a `start` during that period does not disturb the iteration count. The outputs never move outside a `done` cycle. Only the bench scenarios can show that the quotient and remainder are arithmetically correct in both modes, that the latency is exactly sixteen edges, and that a mid-run `start` with different operands leaves the first result intact.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int unsigned DIV_W = 16;

    typedef enum logic {
        DM_INT  = 1'b0,
        DM_FRAC = 1'b1
    } div_mode_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
    } div_flags_t;

    function automatic div_flags_t flags_for_quotient(input logic is_zero);
        div_flags_t f;
        f.carry = 1'b0;
        f.ovf   = 1'b0;
        f.zero  = is_zero;
        return f;
    endfunction

endpackage

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int unsigned W = sdiv_pkg::DIV_W
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0]   shifted;
    logic [W-1:0] trial;
    logic         fits;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        fits    = (shifted >= {1'b0, den_i});
        trial   = shifted[W-1:0] - den_i;
        rem_o   = fits ? trial : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/sdiv_seq.sv
module sdiv_seq #(
    parameter int unsigned STEPS = sdiv_pkg::DIV_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic shortcut_i,
    output logic launch_o,
    output logic busy_o,
    output logic finish_o,
    output logic done_o
);
    localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;

    assign launch_o = start_i && !busy_q;
    assign finish_o = busy_q && (cnt_q == LAST);
    assign busy_o   = busy_q;
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (launch_o && shortcut_i) || finish_o;
            if (launch_o && !shortcut_i) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) busy_q <= 1'b0;
            end
        end
    end

    // R4: every busy period closes with a done pulse
    a_r4_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_q)
        else $error("busy dropped without done");

    // R8: a start during iteration does not restart the count
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1))
        else $error("start disturbed running division");
endmodule

// File: rtl/shift_sub_divider.sv
module shift_sub_divider #(
    parameter int unsigned W = sdiv_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         frac_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         carry_flag,
    output logic         ovf_flag,
    output logic         zero_flag,
    output logic         done
);
    import sdiv_pkg::*;

    logic [W-1:0] wrem_q, wquo_q, wden_q;
    logic [W-1:0] nrem, nquo;
    logic [W-1:0] quo_q, rem_q;
    div_flags_t   flags_q;
    div_mode_e    mode;
    logic         div_zero, frac_ovf, shortcut;
    logic         launch, busy, finish;

    assign mode     = div_mode_e'(frac_mode);
    assign div_zero = (divisor == '0);
    assign frac_ovf = (mode == DM_FRAC) && !div_zero && (dividend >= divisor);
    assign shortcut = div_zero || frac_ovf;

    sdiv_seq #(.STEPS(W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .shortcut_i (shortcut),
        .launch_o   (launch),
        .busy_o     (busy),
        .finish_o   (finish),
        .done_o     (done)
    );

    sdiv_step #(.W(W)) u_step (
        .rem_i (wrem_q),
        .quo_i (wquo_q),
        .den_i (wden_q),
        .rem_o (nrem),
        .quo_o (nquo)
    );

    // Working registers: fraction mode starts with the dividend as the
    // partial remainder and an empty quotient, so zeros shift in for free.
    always_ff @(posedge clk) begin
        if (rst) begin
            wrem_q <= '0;
            wquo_q <= '0;
            wden_q <= '0;
        end else if (launch && !shortcut) begin
            wden_q <= divisor;
            if (mode == DM_FRAC) begin
                wrem_q <= dividend;
                wquo_q <= '0;
            end else begin
                wrem_q <= '0;
                wquo_q <= dividend;
            end
        end else if (busy) begin
            wrem_q <= nrem;
            wquo_q <= nquo;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q   <= '0;
            rem_q   <= '0;
            flags_q <= '0;
        end else if (launch && div_zero) begin
            quo_q   <= '1;
            rem_q   <= '1;
            flags_q <= '{carry: 1'b1, ovf: 1'b0, zero: 1'b0};
        end else if (launch && frac_ovf) begin
            quo_q   <= '1;
            rem_q   <= dividend;
            flags_q <= '{carry: 1'b0, ovf: 1'b1, zero: 1'b0};
        end else if (finish) begin
            quo_q   <= nquo;
            rem_q   <= nrem;
            flags_q <= flags_for_quotient(nquo == '0);
        end
    end

    assign quotient   = quo_q;
    assign remainder  = rem_q;
    assign carry_flag = flags_q.carry;
    assign ovf_flag   = flags_q.ovf;
    assign zero_flag  = flags_q.zero;

    // R1, R2: partial remainder stays below the divisor while iterating
    a_r1_partial_below: assert property (@(posedge clk) disable iff (rst)
        busy |-> (wrem_q < wden_q))
        else $error("partial remainder not below divisor");

    // R3: zero divisor answers in one cycle with fixed values
    a_r3_div_zero: assert property (@(posedge clk) disable iff (rst)
        (launch && divisor == '0) |=>
            (done && carry_flag && !ovf_flag && !zero_flag && quotient == '1 && remainder == '1))
        else $error("divide-by-zero result wrong");

    // R5: fraction overflow answers in one cycle
    a_r5_frac_overflow: assert property (@(posedge clk) disable iff (rst)
        (launch && frac_mode && divisor != '0 && dividend >= divisor) |=>
            (done && ovf_flag && !carry_flag && !zero_flag && quotient == '1
             && remainder == $past(dividend)))
        else $error("fraction overflow result wrong");

    // R6: zero flag tracks the presented quotient
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> (zero_flag == (quotient == '0)))
        else $error("zero flag mismatch");

    // R7: outputs move only together with done
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder)
                   && $stable(carry_flag) && $stable(ovf_flag) && $stable(zero_flag)))
        else $error("outputs changed without done");
endmodule

// File: tb/test_shift_sub_divider.sv
module test_shift_sub_divider;

    typedef struct {
        logic [15:0] q;
        logic [15:0] r;
        logic        c;
        logic        v;
        logic        z;
        int          at;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        frac_mode = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [15:0] quotient, remainder;
    logic        carry_flag, ovf_flag, zero_flag, done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    exp_item_t sb[$];
    exp_item_t last;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shift_sub_divider i_shift_sub_divider (
        .clk(clk), .rst(rst), .start(start), .frac_mode(frac_mode),
        .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .remainder(remainder),
        .carry_flag(carry_flag), .ovf_flag(ovf_flag), .zero_flag(zero_flag),
        .done(done)
    );

    // Monitor: pop and compare on each done pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                n_checks++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R4/R8 extra done: actual=done expected=idle at cycle %0d", cyc);
                end else begin
                    exp_item_t e;
                    e = sb.pop_front();
                    last = e;
                    if (cyc != e.at || quotient != e.q || remainder != e.r ||
                        carry_flag != e.c || ovf_flag != e.v || zero_flag != e.z) begin
                        n_fail++;
                        $display("FAIL %s: actual cyc=%0d q=%h r=%h cvz=%b%b%b expected cyc=%0d q=%h r=%h cvz=%b%b%b",
                                 e.tag, cyc, quotient, remainder, carry_flag, ovf_flag, zero_flag,
                                 e.at, e.q, e.r, e.c, e.v, e.z);
                    end
                end
            end else if (sb.size() != 0 && cyc > sb[0].at) begin
                exp_item_t e;
                e = sb.pop_front();
                n_checks++;
                n_fail++;
                $display("FAIL R4 %s: actual=no done expected=done at cycle %0d", e.tag, e.at);
            end
        end
    end

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_op(input logic fm, input logic [15:0] a, input logic [15:0] b,
                         input string tag);
        exp_item_t e;
        logic [31:0] num;
        e.tag = tag;
        if (b == 16'h0) begin
            e.q = 16'hFFFF; e.r = 16'hFFFF; e.c = 1; e.v = 0; e.z = 0; e.at = cyc + 1;
        end else if (fm && a >= b) begin
            e.q = 16'hFFFF; e.r = a; e.c = 0; e.v = 1; e.z = 0; e.at = cyc + 1;
        end else begin
            num = fm ? {a, 16'h0} : {16'h0, a};
            e.q = 16'(num / {16'h0, b});
            e.r = 16'(num % {16'h0, b});
            e.c = 0; e.v = 0; e.z = (e.q == 16'h0);
            e.at = cyc + 1 + 16;
        end
        sb.push_back(e);
        start = 1'b1; frac_mode = fm; dividend = a; divisor = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (quotient !== 16'h0 || remainder !== 16'h0 || carry_flag !== 0 ||
            ovf_flag !== 0 || zero_flag !== 0 || done !== 0) begin
            n_fail++;
            $display("FAIL R9 reset: actual q=%h r=%h cvz=%b%b%b done=%b expected all zero",
                     quotient, remainder, carry_flag, ovf_flag, zero_flag, done);
        end

        // R1 integer division
        do_op(0, 16'd1000, 16'd7, "R1 1000/7");        drain();
        do_op(0, 16'hFFFF, 16'h0001, "R1 max/1");       drain();
        do_op(0, 16'hBEEF, 16'h0023, "R1 beef/23");     drain();
        do_op(0, 16'h1234, 16'h1234, "R1 equal");       drain();
        do_op(0, 16'h0005, 16'h1234, "R6 zero quot");   drain();
        // R2 fraction division
        do_op(1, 16'd1, 16'd3, "R2 1/3");               drain();
        do_op(1, 16'h8000, 16'hFFFF, "R2 8000/ffff");   drain();
        do_op(1, 16'hFFFE, 16'hFFFF, "R2 near one");    drain();
        do_op(1, 16'h0123, 16'h4567, "R2 123/4567");    drain();
        do_op(1, 16'h0000, 16'h0005, "R6 frac zero");   drain();
        // R3 divide by zero, both modes
        do_op(0, 16'h4321, 16'h0000, "R3 int div0");    drain();
        do_op(1, 16'h0000, 16'h0000, "R3 frac div0");   drain();
        // R5 fraction overflow
        do_op(1, 16'h0007, 16'h0007, "R5 equal");       drain();
        do_op(1, 16'h9000, 16'h0100, "R5 above");       drain();

        // R8: stray start with other operands during iteration
        do_op(0, 16'hBEEF, 16'h0023, "R8 first result");
        repeat (5) @(negedge clk);
        start = 1'b1; frac_mode = 1'b1; dividend = 16'h0001; divisor = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (20) @(negedge clk);

        // R7: outputs hold after done
        n_checks++;
        if (quotient !== last.q || remainder !== last.r || carry_flag !== last.c ||
            ovf_flag !== last.v || zero_flag !== last.z) begin
            n_fail++;
            $display("FAIL R7 hold: actual q=%h r=%h expected q=%h r=%h",
                     quotient, remainder, last.q, last.r);
        end

        // Back-to-back: shortcut right after iterating result
        do_op(1, 16'h2000, 16'h6000, "R2 third");
        drain();
        do_op(0, 16'h0001, 16'h0000, "R3 after iterate");
        drain();
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R4 watchdog: actual=hung expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule